// File: doc/BRIEF.md
# Keyboard Scan Code Port

This block sits between a keyboard's two-wire serial link and the host's I/O read path. It watches the keyboard clock and data wires and assembles each serial frame into one byte. When a frame is good, the byte is placed in a one-byte holding register and the keyboard interrupt line is raised. A single read of the data port at I/O address 0x60 returns that byte and acknowledges the interrupt. The byte is the raw position code of the key, not a character.

Every keystroke produces two bytes and therefore two interrupts. The press byte has bit 7 clear. The release byte has the same low seven bits with bit 7 set. Modifier keys such as Shift send their own press and release bytes, exactly like any other key. Frames that fail the parity check or the stop-bit check are thrown away. A byte that arrives while the previous one is still unread is also thrown away, and an overrun flag records the loss.

A second port reports the status of the holding register. A watchdog inside the frame receiver abandons a frame that stalls partway, so the next frame starts cleanly.

Top module: `kbd_scan_port`

## Requirements
- R1: After reset, `kbd_irq` is low, a status read returns 0x00 and the receiver waits for a start bit.
- R2: A frame is eleven bits, sampled on the falling edges of `kbd_clk`: a start bit of 0, eight data bits sent LSB first, an odd parity bit, and a stop bit of 1. When a good frame ends, its byte is held and `kbd_irq` goes high.
- R3: A read at address 0x60 returns the held byte on `rd_data` in the cycle after `rd_en`. From that same cycle, `kbd_irq` is low until the next good frame.
- R4: The held byte equals the transmitted code bit for bit. Press codes have bit 7 clear and release codes have bit 7 set. Status bit 2 is a copy of bit 7 of the held byte.
- R5: A frame whose data and parity bits hold an even number of ones is discarded. `kbd_irq` stays low and the held byte is unchanged.
- R6: A frame whose stop bit is 0 is discarded in the same way.
- R7: If a good frame ends while a byte is pending, the new byte is dropped, the held byte is kept and status bit 1 (overrun) is set. A data-port read clears both the overrun flag and the pending flag.
- R8: A read at address 0x64 returns status: bit 0 is pending, bit 1 is overrun, bit 2 is release, and the other bits are 0. A status read changes neither `kbd_irq` nor the flags.
- R9: A read at any other address returns 0x00 and has no effect on `kbd_irq`, the held byte or the flags.
- R10: A frame that sees no falling edge of `kbd_clk` for `TIMEOUT_CYC` clock cycles is abandoned. The next complete frame is received correctly.
- R11: A falling edge that finds the data line high while the receiver waits for a start bit is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_clk | input | 1 | Serial clock from the keyboard, asynchronous |
| kbd_data | input | 1 | Serial data from the keyboard, asynchronous |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rd_addr | input | 8 | I/O port address of the read |
| rd_data | output | 8 | Read result, valid in the cycle after `rd_en` |
| kbd_irq | output | 1 | Interrupt request, high while a byte is pending |

## Verification
If the bit counter is off by one, the byte in the holding register is shifted or the frame is rejected. Either fault appears on the very next data read, or as a missing interrupt within about three clock cycles of the stop bit. A pending or overrun flag that is set wrongly, or cleared at the wrong time, shows on `kbd_irq` or on the status port in the cycle after the event that should have changed it. For that reason the status port is read after each overrun step and after each ignored read. If a partial frame is left stuck in the receiver, the fault stays hidden until the following frame, which then decodes to a wrong byte. The timeout check therefore compares the whole byte of the frame that comes after the stall.

// File: rtl/kbd_scan_port.sv
module kbd_scan_port #(
  parameter int          TIMEOUT_CYC = 2000,
  parameter logic [7:0]  DATA_PORT   = 8'h60,
  parameter logic [7:0]  STATUS_PORT = 8'h64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk,
  input  logic       kbd_data,
  input  logic       rd_en,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       kbd_irq
);
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);
  localparam int LAST_BIT = 10;

  logic [2:0]    clk_s;
  logic [1:0]    dat_s;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          par_bit;
  logic [TW-1:0] idle_cnt;
  logic [7:0]    held;
  logic          pending, overrun;

  wire fall       = clk_s[2] & ~clk_s[1];
  wire bit_in     = dat_s[1];
  wire frame_end  = fall && (bit_cnt == 4'(LAST_BIT));
  wire frame_good = frame_end && bit_in && (^{shreg, par_bit});
  wire data_rd    = rd_en && (rd_addr == DATA_PORT);
  wire stat_rd    = rd_en && (rd_addr == STATUS_PORT);
  wire stall      = (bit_cnt != 4'd0) && !fall && (idle_cnt == TW'(TIMEOUT_CYC - 1));

  assign kbd_irq = pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_s <= 3'b111;
      dat_s <= 2'b11;
    end else begin
      clk_s <= {clk_s[1:0], kbd_clk};
      dat_s <= {dat_s[0], kbd_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      idle_cnt <= '0;
    end else begin
      if (bit_cnt == 4'd0 || fall) idle_cnt <= '0;
      else if (!stall)             idle_cnt <= idle_cnt + 1'b1;
      else                         idle_cnt <= '0;

      if (stall) begin
        bit_cnt <= '0;
      end else if (fall) begin
        if (bit_cnt == 4'd0) begin
          if (!bit_in) bit_cnt <= 4'd1;
        end else if (bit_cnt <= 4'd8) begin
          shreg   <= {bit_in, shreg[7:1]};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd9) begin
          par_bit <= bit_in;
          bit_cnt <= bit_cnt + 4'd1;
        end else begin
          bit_cnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= '0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (frame_good && (!pending || data_rd)) begin
        held    <= shreg;
        pending <= 1'b1;
      end else if (data_rd) begin
        pending <= 1'b0;
      end
      if (frame_good && pending && !data_rd) overrun <= 1'b1;
      else if (data_rd)                      overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (data_rd) rd_data <= held;
    else if (stat_rd) rd_data <= {5'b0, held[7], overrun, pending};
    else if (rd_en)   rd_data <= '0;
  end

  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'(LAST_BIT));

  assert_irq_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !kbd_irq |=> (!kbd_irq || $past(frame_good)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_good) |=> !kbd_irq);

  assert_bad_frame_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_good && !kbd_irq) |=> !kbd_irq);

  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_good && pending && !data_rd) |=> (overrun && kbd_irq && $stable(held)));

  assert_status_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && kbd_irq) |=> kbd_irq);

  assert_stall_abandon_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (bit_cnt == 4'd0));
endmodule

// File: tb/test_kbd_scan_port.sv
module test_kbd_scan_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_clk = 1'b1;
  logic       kbd_data = 1'b1;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       kbd_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  localparam int HALF = 6;

  always #2 clk = ~clk;

  kbd_scan_port i_kbd_scan_port (
    .clk(clk), .rst_n(rst_n), .kbd_clk(kbd_clk), .kbd_data(kbd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .kbd_irq(kbd_irq)
  );

  // [9]=corrupt parity, [8]=corrupt stop, [7:0]=code
  localparam logic [9:0] VEC [10] = '{
    {2'b00, 8'h1E}, {2'b00, 8'h9E}, {2'b00, 8'h2A}, {2'b00, 8'hAA},
    {2'b00, 8'h00}, {2'b00, 8'hFF}, {2'b10, 8'h1E}, {2'b01, 8'h33},
    {2'b00, 8'h80}, {2'b00, 8'h7F}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse_bit(input logic b);
    kbd_data = b;
    repeat (HALF) @(negedge clk);
    kbd_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    kbd_clk = 1'b1;
  endtask

  task automatic send(input logic [7:0] code, input bit bad_par, input bit bad_stop);
    logic par;
    par = ~(^code) ^ bad_par;
    @(negedge clk);
    pulse_bit(1'b0);
    for (int i = 0; i < 8; i++) pulse_bit(code[i]);
    pulse_bit(par);
    pulse_bit(~bad_stop);
    kbd_data = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] last;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {7'b0, kbd_irq}, 8'h00);
    rd(8'h64, v); check("R1 status", v, 8'h00);

    last = 8'h00;
    for (int k = 0; k < 10; k++) begin
      send(VEC[k][7:0], VEC[k][9], VEC[k][8]);
      if (VEC[k][9] || VEC[k][8]) begin
        check(VEC[k][9] ? "R5 irq" : "R6 irq", {7'b0, kbd_irq}, 8'h00);
        rd(8'h60, v);
        check(VEC[k][9] ? "R5 held" : "R6 held", v, last);
      end else begin
        check("R2 irq", {7'b0, kbd_irq}, 8'h01);
        rd(8'h64, v);
        check("R4 R8 status", v, {5'b0, VEC[k][7], 2'b01});
        rd(8'h60, v);
        check("R3 R4 data", v, VEC[k][7:0]);
        check("R3 ack", {7'b0, kbd_irq}, 8'h00);
        last = VEC[k][7:0];
      end
    end

    // R7 overrun
    send(8'h15, 1'b0, 1'b0);
    send(8'h95, 1'b0, 1'b0);
    rd(8'h64, v); check("R7 R8 status", v, 8'h03);
    check("R8 irq kept", {7'b0, kbd_irq}, 8'h01);
    rd(8'h60, v); check("R7 held", v, 8'h15);
    rd(8'h64, v); check("R7 cleared", v, 8'h00);

    // R9 other address
    send(8'h9C, 1'b0, 1'b0);
    rd(8'h61, v); check("R9 data", v, 8'h00);
    check("R9 irq", {7'b0, kbd_irq}, 8'h01);
    rd(8'h64, v); check("R9 status", v, 8'h05);
    rd(8'h60, v); check("R9 held", v, 8'h9C);

    // R11 idle-high edges ignored
    for (int i = 0; i < 3; i++) pulse_bit(1'b1);
    send(8'h2C, 1'b0, 1'b0);
    rd(8'h60, v); check("R11 data", v, 8'h2C);

    // R10 stall then clean frame
    @(negedge clk);
    pulse_bit(1'b0);
    pulse_bit(1'b1);
    pulse_bit(1'b0);
    kbd_data = 1'b1;
    repeat (2100) @(negedge clk);
    check("R10 no irq", {7'b0, kbd_irq}, 8'h00);
    send(8'h4B, 1'b0, 1'b0);
    check("R10 irq", {7'b0, kbd_irq}, 8'h01);
    rd(8'h60, v); check("R10 data", v, 8'h4B);

    // R1 reset mid-pending
    send(8'h11, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {7'b0, kbd_irq}, 8'h00);
    rd(8'h64, v); check("R1 status after reset", v, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule